// File: doc/BRIEF.md
# Calendar Alarm Match Unit

This block watches the calendar time kept by a timekeeping core and raises a sticky alarm flag when the current minute, hour, day of month and day of week agree with a programmed alarm. Each of the four alarm fields can be left out of the match on its own, so one alarm can fire daily, weekly, monthly or every hour. The resolution is one minute. The comparison happens only when the core pulses its minute-tick strobe, which marks the moment the seconds wrap to 00. Seconds are never compared.

Software reaches the block through a simple single-cycle register bus. Four byte-wide alarm registers sit at consecutive addresses. A control byte holds the interrupt enable and a status byte holds the alarm flag. An active-low interrupt output goes low while the flag is set and interrupts are enabled. Software clears the flag by writing 0 to its bit.

Top module: `cal_alarm_match`

## Requirements
- R1: After reset, every alarm register reads 0x80 (field disabled, value 0). The control byte (address 0) and the status byte (address 1) read 0x00, and `irq_n` is 1.
- R2: The alarm registers sit at addresses 2, 3, 4 and 5, holding minute, hour, date and weekday in that order. In each, bit 7 is the enable. The stored value is bits 6:0 for minute, bits 5:0 for hour and date, and bits 2:0 for weekday. Writes read back with all other bits returning 0.
- R3: When `min_tick` is 1 and every enabled field equals its calendar input, the flag (status byte bit 3) reads 1 from the next clock cycle.
- R4: A field whose bit 7 is 1 is ignored. A difference in that field alone does not stop a match.
- R5: When all four fields have bit 7 set to 1, the flag never sets.
- R6: Without `min_tick`, matching calendar inputs do not set the flag.
- R7: The flag stays set until software writes the status byte with bit 3 at 0, which clears it on the next cycle. Writing 1 to bit 3 leaves the flag unchanged.
- R8: A match that arrives in the same cycle as a clearing write wins, and the flag stays set.
- R9: `irq_n` is 0 exactly while the flag and the interrupt enable (control byte bit 1) are both 1.
- R10: A mismatch on any enabled field at the tick leaves the flag clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 3 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for `bus_addr` (combinational) |
| min_tick | input | 1 | One-cycle strobe at minute rollover |
| cur_min | input | 7 | Current minute, BCD |
| cur_hour | input | 6 | Current hour, BCD, 24-hour |
| cur_date | input | 6 | Current day of month, BCD |
| cur_wday | input | 3 | Current day of week |
| irq_n | output | 1 | Active-low alarm interrupt |

## Verification
The assertions assume that `min_tick` is a single-cycle pulse and that the calendar inputs hold steady in the cycle it is high. The bench applies new calendar values one cycle before each tick and holds them through it. It drives the bus and the tick on the falling edge, so each write and each comparison lands on exactly one rising edge. For the case where a match meets a clear, the bench raises the clearing write and the tick together, on purpose.

// File: rtl/cal_alarm_match.sv
module cal_alarm_match #(
  parameter int ADDR_W    = 3,
  parameter int ALM_BASE  = 2,
  parameter int CTRL_ADDR = 0,
  parameter int STAT_ADDR = 1,
  parameter int IE_BIT    = 1,
  parameter int FLAG_BIT  = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [7:0]        bus_wdata,
  output logic [7:0]        bus_rdata,
  input  logic              min_tick,
  input  logic [6:0]        cur_min,
  input  logic [5:0]        cur_hour,
  input  logic [5:0]        cur_date,
  input  logic [2:0]        cur_wday,
  output logic              irq_n
);

  localparam logic [ADDR_W-1:0] A_MIN  = ADDR_W'(ALM_BASE);
  localparam logic [ADDR_W-1:0] A_HOUR = ADDR_W'(ALM_BASE + 1);
  localparam logic [ADDR_W-1:0] A_DATE = ADDR_W'(ALM_BASE + 2);
  localparam logic [ADDR_W-1:0] A_WDAY = ADDR_W'(ALM_BASE + 3);
  localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(CTRL_ADDR);
  localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(STAT_ADDR);

  logic [7:0] alm_min, alm_hour, alm_date, alm_wday;
  logic       ie_q, flag_q;
  logic [3:0] en, eq;
  logic       hit, clr_wr;

  assign en = {~alm_wday[7], ~alm_date[7], ~alm_hour[7], ~alm_min[7]};
  assign eq = {cur_wday == alm_wday[2:0], cur_date == alm_date[5:0],
               cur_hour == alm_hour[5:0], cur_min == alm_min[6:0]};
  assign hit    = (|en) && ((eq | ~en) == 4'hF);
  assign clr_wr = bus_we && bus_addr == A_STAT && !bus_wdata[FLAG_BIT];
  assign irq_n  = !(flag_q && ie_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      alm_min  <= 8'h80;
      alm_hour <= 8'h80;
      alm_date <= 8'h80;
      alm_wday <= 8'h80;
      ie_q     <= 1'b0;
    end else if (bus_we) begin
      case (bus_addr)
        A_MIN:  alm_min  <= {bus_wdata[7], bus_wdata[6:0]};
        A_HOUR: alm_hour <= {bus_wdata[7], 1'b0, bus_wdata[5:0]};
        A_DATE: alm_date <= {bus_wdata[7], 1'b0, bus_wdata[5:0]};
        A_WDAY: alm_wday <= {bus_wdata[7], 4'b0, bus_wdata[2:0]};
        A_CTRL: ie_q     <= bus_wdata[IE_BIT];
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                flag_q <= 1'b0;
    else if (min_tick && hit)  flag_q <= 1'b1;
    else if (clr_wr)           flag_q <= 1'b0;
  end

  always_comb begin
    bus_rdata = 8'h00;
    case (bus_addr)
      A_MIN:  bus_rdata = alm_min;
      A_HOUR: bus_rdata = alm_hour;
      A_DATE: bus_rdata = alm_date;
      A_WDAY: bus_rdata = alm_wday;
      A_CTRL: bus_rdata[IE_BIT]   = ie_q;
      A_STAT: bus_rdata[FLAG_BIT] = flag_q;
      default: ;
    endcase
  end

  AST_SET_ONLY_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag_q) |-> $past(min_tick)); // R6

  AST_ALL_OFF_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    (min_tick && en == 4'h0) |=> !$rose(flag_q)); // R5

  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_q && !clr_wr) |=> flag_q); // R7

  AST_MATCH_BEATS_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (min_tick && hit && clr_wr) |=> flag_q); // R8

  AST_NO_IRQ_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    (!ie_q || !flag_q) |-> irq_n); // R9

endmodule

// File: tb/cal_alarm_match_test.sv
module cal_alarm_match_test;
  logic       clk = 0, rst_n = 0;
  logic       bus_we = 0;
  logic [2:0] bus_addr = 0;
  logic [7:0] bus_wdata = 0, bus_rdata;
  logic       min_tick = 0;
  logic [6:0] cur_min = 0;
  logic [5:0] cur_hour = 0, cur_date = 0;
  logic [2:0] cur_wday = 0;
  logic       irq_n;
  int checks = 0, fails = 0;
  bit done = 0;

  always #2 clk = ~clk;

  cal_alarm_match uut (.clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .min_tick(min_tick),
    .cur_min(cur_min), .cur_hour(cur_hour), .cur_date(cur_date),
    .cur_wday(cur_wday), .irq_n(irq_n));

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk); bus_we = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_we = 0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] d);
    @(negedge clk); bus_addr = a; #1 d = bus_rdata;
  endtask

  task automatic tick(input logic [6:0] m, input logic [5:0] h,
                      input logic [5:0] dt, input logic [2:0] wd);
    @(negedge clk); cur_min = m; cur_hour = h; cur_date = dt; cur_wday = wd;
    @(negedge clk); min_tick = 1;
    @(negedge clk); min_tick = 0;
  endtask

  task automatic flag_is(input string req, input int exp);
    logic [7:0] d;
    rd(3'd1, d); chk(req, d[3], exp);
  endtask

  task automatic clear_flag();
    wr(3'd1, 8'h00);
  endtask

  task automatic t_reset();
    logic [7:0] d;
    for (int a = 2; a <= 5; a++) begin rd(3'(a), d); chk("R1 alarm reg", d, 8'h80); end
    rd(3'd0, d); chk("R1 ctrl", d, 0);
    rd(3'd1, d); chk("R1 status", d, 0);
    chk("R1 irq_n", irq_n, 1);
  endtask

  task automatic t_regs();
    logic [7:0] d;
    wr(3'd2, 8'hFF); rd(3'd2, d); chk("R2 minute mask", d, 8'hFF);
    wr(3'd3, 8'hFF); rd(3'd3, d); chk("R2 hour mask", d, 8'hBF);
    wr(3'd4, 8'h7F); rd(3'd4, d); chk("R2 date mask", d, 8'h3F);
    wr(3'd5, 8'h7F); rd(3'd5, d); chk("R2 weekday mask", d, 8'h07);
  endtask

  task automatic t_match();
    wr(3'd2, 8'h30); wr(3'd3, 8'h12); wr(3'd4, 8'h15); wr(3'd5, 8'h03);
    tick(7'h30, 6'h12, 6'h15, 3'd3);
    flag_is("R3 full match sets flag", 1);
    clear_flag(); flag_is("R7 clear by writing 0", 0);
  endtask

  task automatic t_mismatch();
    tick(7'h31, 6'h12, 6'h15, 3'd3); flag_is("R10 minute mismatch", 0);
    tick(7'h30, 6'h12, 6'h15, 3'd4); flag_is("R10 weekday mismatch", 0);
  endtask

  task automatic t_no_tick();
    @(negedge clk); cur_min = 7'h30; cur_hour = 6'h12; cur_date = 6'h15; cur_wday = 3'd3;
    repeat (3) @(negedge clk);
    flag_is("R6 no tick no flag", 0);
  endtask

  task automatic t_disabled_field();
    wr(3'd5, 8'h83); wr(3'd4, 8'h95);
    tick(7'h30, 6'h12, 6'h01, 3'd6);
    flag_is("R4 disabled date/weekday ignored", 1);
    clear_flag();
  endtask

  task automatic t_all_off();
    wr(3'd2, 8'hB0); wr(3'd3, 8'h92); wr(3'd4, 8'h95); wr(3'd5, 8'h83);
    tick(7'h30, 6'h12, 6'h15, 3'd3);
    flag_is("R5 all disabled never sets", 0);
    wr(3'd2, 8'h30);
  endtask

  task automatic t_sticky_irq();
    chk("R9 irq_n idle", irq_n, 1);
    tick(7'h30, 6'h00, 6'h00, 3'd0);
    flag_is("R3 minute-only match", 1);
    chk("R9 irq_n high with ie=0", irq_n, 1);
    wr(3'd0, 8'h02); #1 chk("R9 irq_n low flag&ie", irq_n, 0);
    wr(3'd1, 8'h08); flag_is("R7 write 1 no effect", 1);
    tick(7'h45, 6'h00, 6'h00, 3'd0); flag_is("R7 sticky over mismatch", 1);
    clear_flag(); #1 chk("R9 irq_n released", irq_n, 1);
    wr(3'd0, 8'h00);
  endtask

  task automatic t_prio();
    @(negedge clk); cur_min = 7'h30;
    @(negedge clk); min_tick = 1; bus_we = 1; bus_addr = 3'd1; bus_wdata = 8'h00;
    @(negedge clk); min_tick = 0; bus_we = 0;
    flag_is("R8 match beats clear", 1);
    clear_flag(); flag_is("R8 later clear works", 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset();
    t_regs();
    t_match();
    t_mismatch();
    t_no_tick();
    t_disabled_field();
    t_all_off();
    t_sticky_irq();
    t_prio();
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #100000;
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule